// File: doc/BRIEF.md
# Dual-Channel DAC Latch Controller

This block sits on the register side of a pair of digital-to-analog channels. Each channel has a control word and a data word, both written over a simple strobe-and-address bus. The block decides when a channel's stored data moves into its output latch, and converts the word into the code the converter expects on the way in. The data word can be straight binary or two's complement, and can use either the full 12-bit width or only the low 8 bits.

Each channel picks one of four load triggers. The first loads on every data write, whatever the enable bit says. The second loads on a data write while the channel is enabled. When channel 0 is paired with channel 1, this second trigger holds the load until both data words have been written, then both latches load on the same edge. The third and fourth triggers load on a rising edge of one of two timer inputs.

A latch load raises a per-channel flag, which can drive an interrupt. A calibration request makes a channel busy for a fixed time. While it is busy, that channel's loads and triggers are thrown away.

Top module: `dac_latch_ctrl`

## Requirements
- R1: After reset, both latched codes, both flags, both calibration indicators and the interrupt output are 0.
- R2: Address map: 0 = channel 0 control, 1 = channel 0 data, 2 = channel 1 control, 3 = channel 1 data. Control word bits: [1:0] load trigger, 2 enable, 3 group, 4 format, 5 narrow, 6 calibrate, 7 interrupt enable, 8 flag. With load trigger 0, a data write loads the latch at the same clock edge, whether the enable bit is 0 or 1.
- R3: With load trigger 1 on a channel that is not in a group, a data write loads the latch only when the enable bit is 1. A write while the enable bit is 0 leaves the latched code unchanged.
- R4: With the enable bit set, load trigger 2 loads the stored data on the edge where `trig_a` is first seen high, and load trigger 3 does the same for `trig_b`. A held-high level, the other trigger input, or a cleared enable bit causes no load.
- R5: A group is active when channel 0's group bit is set and both channels use load trigger 1. In a group, a data write does not load until both data words have been written, in either order. Both enabled latches then load on the same edge, and the tracking starts over.
- R6: Any change to either group bit or either load trigger clears the group's record of written data words. A data word written before the change does not count towards the next group load.
- R7: With format bit 1, the most significant bit of the active width is inverted in the latched code. With format bit 0, the code is passed through unchanged.
- R8: With narrow bit 1, the latched code is data bits 7:0 placed in code bits 7:0, and code bits 11:8 are 0. With narrow bit 0, data bits 11:0 are used.
- R9: Writing a control word with the calibrate bit set, while the channel is not already calibrating, makes `cal_o` for that channel read 1 for exactly 64 cycles after the write edge. It then clears by itself.
- R10: While a channel is calibrating, its latch never loads. A trigger edge or data write that arrives during calibration is dropped, and it does not load later.
- R11: A latch load sets the channel's flag. A control write stores bit 8 into the flag, so writing 0 clears it, but a load in the same cycle wins. `irq` is 1 when any channel has both its flag and its interrupt-enable bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 2 | Register select (see R2) |
| wr_data | input | 12 | Write data |
| trig_a | input | 1 | First timer trigger input |
| trig_b | input | 1 | Second timer trigger input |
| code0 | output | 12 | Channel 0 latched code |
| code1 | output | 12 | Channel 1 latched code |
| flag_o | output | 2 | Per-channel load flag |
| cal_o | output | 2 | Per-channel calibration-in-progress indicator |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle. A calibrating channel's code holds steady, and a calibration run lasts exactly the configured length. Every load is followed by a set flag, the interrupt never rises without a flag, and an active group never loads channel 0 alone. Other behaviour only the bench's scenarios can show: the data conversions, which trigger input each mode responds to, the fact that held trigger levels and dropped events are ignored, and the reset of group tracking when the configuration changes.

// File: rtl/dac_lc_pkg.sv
package dac_lc_pkg;
  localparam int CODE_W   = 12;
  localparam int NARROW_W = 8;
  localparam int NCH      = 2;
  localparam int ADDR_W   = $clog2(2 * NCH);

  // control word bit positions
  localparam int B_LSEL = 0;
  localparam int B_EN   = 2;
  localparam int B_GRP  = 3;
  localparam int B_FMT  = 4;
  localparam int B_RES  = 5;
  localparam int B_CAL  = 6;
  localparam int B_IE   = 7;
  localparam int B_FLAG = 8;

  typedef enum logic [1:0] {
    LS_WRITE     = 2'd0,
    LS_WRITE_GRP = 2'd1,
    LS_TRIG_A    = 2'd2,
    LS_TRIG_B    = 2'd3
  } lsel_e;

  typedef struct packed {
    logic  flag;
    logic  ie;
    logic  res8;
    logic  fmt;
    logic  grp;
    logic  en;
    lsel_e lsel;
  } ctl_t;

  // data word to latched code: narrow select, then offset flip of the top bit
  function automatic logic [CODE_W-1:0] to_code(input logic [CODE_W-1:0] dat,
                                                input logic fmt,
                                                input logic res8);
    logic [CODE_W-1:0] raw;
    logic [CODE_W-1:0] msb;
    raw = res8 ? {{(CODE_W-NARROW_W){1'b0}}, dat[NARROW_W-1:0]} : dat;
    msb = res8 ? (CODE_W'(1) << (NARROW_W-1)) : (CODE_W'(1) << (CODE_W-1));
    return fmt ? (raw ^ msb) : raw;
  endfunction
endpackage

// File: rtl/dac_lc_edge.sv
module dac_lc_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] lvl_q;

  for (genvar g = 0; g < N; g++) begin : g_edge
    always_ff @(posedge clk) begin
      if (!rst_n) lvl_q[g] <= 1'b0;
      else        lvl_q[g] <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~lvl_q[g];
  end
endmodule

// File: rtl/dac_lc_group.sv
module dac_lc_group
  import dac_lc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] grp,
  input  lsel_e          lsel0,
  input  lsel_e          lsel1,
  input  logic [NCH-1:0] en,
  input  logic [NCH-1:0] dat_we_ok,
  output logic           grp_on,
  output logic [NCH-1:0] grp_load
);
  localparam int CFG_W = NCH + 4;

  logic [CFG_W-1:0] cfg, cfg_q;
  logic [NCH-1:0]   seen_q, seen_nxt;
  logic             clr, fire;

  assign grp_on = grp[0] & (lsel0 == LS_WRITE_GRP) & (lsel1 == LS_WRITE_GRP);
  assign cfg    = {grp, lsel0, lsel1};
  assign clr    = ~grp_on | (cfg != cfg_q);

  always_comb begin
    seen_nxt = ((clr ? '0 : seen_q) | dat_we_ok) & {NCH{grp_on}};
    fire     = grp_on & (&seen_nxt);
    grp_load = {NCH{fire}} & en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= '0;
      cfg_q  <= '0;
    end else begin
      seen_q <= fire ? '0 : seen_nxt;
      cfg_q  <= cfg;
    end
  end
endmodule

// File: rtl/dac_lc_chan.sv
module dac_lc_chan
  import dac_lc_pkg::*;
#(
  parameter int CAL_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              dat_we,
  input  logic [CODE_W-1:0] wdata,
  input  logic              rise_a,
  input  logic              rise_b,
  input  logic              in_group,
  input  logic              grp_load,
  output ctl_t              ctl_q,
  output logic              busy,
  output logic              load_evt,
  output logic              dat_we_ok,
  output logic [CODE_W-1:0] code
);
  localparam int CNT_W = $clog2(CAL_CYCLES + 1);

  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] dat_q, dat_nxt;
  logic              cal_start, imm, trg;

  assign busy      = (cnt != '0);
  assign cal_start = ctl_we & wdata[B_CAL] & ~busy;
  assign dat_nxt   = dat_we ? wdata : dat_q;
  assign dat_we_ok = dat_we & ~busy;

  always_comb begin
    imm = dat_we & ((ctl_q.lsel == LS_WRITE) |
                    ((ctl_q.lsel == LS_WRITE_GRP) & ctl_q.en & ~in_group));
    trg = ctl_q.en & (((ctl_q.lsel == LS_TRIG_A) & rise_a) |
                      ((ctl_q.lsel == LS_TRIG_B) & rise_b));
    load_evt = ~busy & (imm | trg | grp_load);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      dat_q <= '0;
      cnt   <= '0;
      code  <= '0;
    end else begin
      if (ctl_we) begin
        ctl_q.lsel <= lsel_e'(wdata[B_LSEL+1:B_LSEL]);
        ctl_q.en   <= wdata[B_EN];
        ctl_q.grp  <= wdata[B_GRP];
        ctl_q.fmt  <= wdata[B_FMT];
        ctl_q.res8 <= wdata[B_RES];
        ctl_q.ie   <= wdata[B_IE];
        ctl_q.flag <= wdata[B_FLAG];
      end
      if (load_evt) begin
        ctl_q.flag <= 1'b1;
        code       <= to_code(dat_nxt, ctl_q.fmt, ctl_q.res8);
      end
      if (dat_we) dat_q <= wdata;
      if (cal_start)  cnt <= CNT_W'(CAL_CYCLES);
      else if (busy)  cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/dac_latch_ctrl.sv
module dac_latch_ctrl
  import dac_lc_pkg::*;
#(
  parameter int CAL_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              trig_a,
  input  logic              trig_b,
  output logic [CODE_W-1:0] code0,
  output logic [CODE_W-1:0] code1,
  output logic [NCH-1:0]    flag_o,
  output logic [NCH-1:0]    cal_o,
  output logic              irq
);
  ctl_t              ctl_w  [NCH];
  logic [CODE_W-1:0] code_w [NCH];
  logic [NCH-1:0]    busy_w, load_w, we_ok_w, grp_load_w, en_w, grp_w, ie_w;
  logic [1:0]        rise_w;
  logic              grp_on_w;

  dac_lc_edge #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl({trig_b, trig_a}), .rise(rise_w)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dac_lc_chan #(.CAL_CYCLES(CAL_CYCLES)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (wr_en & (wr_addr == ADDR_W'(2 * i))),
      .dat_we   (wr_en & (wr_addr == ADDR_W'(2 * i + 1))),
      .wdata    (wr_data),
      .rise_a   (rise_w[0]),
      .rise_b   (rise_w[1]),
      .in_group (grp_on_w),
      .grp_load (grp_load_w[i]),
      .ctl_q    (ctl_w[i]),
      .busy     (busy_w[i]),
      .load_evt (load_w[i]),
      .dat_we_ok(we_ok_w[i]),
      .code     (code_w[i])
    );
    assign en_w[i]   = ctl_w[i].en;
    assign grp_w[i]  = ctl_w[i].grp;
    assign ie_w[i]   = ctl_w[i].ie;
    assign flag_o[i] = ctl_w[i].flag;
  end

  dac_lc_group u_grp (
    .clk      (clk),
    .rst_n    (rst_n),
    .grp      (grp_w),
    .lsel0    (ctl_w[0].lsel),
    .lsel1    (ctl_w[1].lsel),
    .en       (en_w),
    .dat_we_ok(we_ok_w),
    .grp_on   (grp_on_w),
    .grp_load (grp_load_w)
  );

  assign code0 = code_w[0];
  assign code1 = code_w[1];
  assign cal_o = busy_w;
  assign irq   = |(flag_o & ie_w);
endmodule

// File: rtl/dac_lc_checker.sv
module dac_lc_checker
  import dac_lc_pkg::*;
#(
  parameter int CAL_CYCLES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] code0,
  input logic [CODE_W-1:0] code1,
  input logic [NCH-1:0]    busy,
  input logic [NCH-1:0]    load,
  input logic [NCH-1:0]    flag,
  input logic [NCH-1:0]    en,
  input logic              grp_on,
  input logic              irq
);
  localparam int RUN_W = $clog2(CAL_CYCLES + 2);

  logic [RUN_W-1:0] run [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_run
    always_ff @(posedge clk) begin
      if (!rst_n)       run[i] <= '0;
      else if (busy[i]) run[i] <= run[i] + 1'b1;
      else              run[i] <= '0;
    end

    // R9: a calibration run ends after exactly the configured number of cycles
    p_cal_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[i]) |-> (run[i] == RUN_W'(CAL_CYCLES)));

    p_cal_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      run[i] <= RUN_W'(CAL_CYCLES));

    // R11: a load always leaves the flag set
    p_flag_on_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      load[i] |=> flag[i]);
  end

  // R10: a calibrating channel keeps its code
  p_cal_hold0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy[0] |=> $stable(code0));
  p_cal_hold1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy[1] |=> $stable(code1));

  // R5: an active group never loads channel 0 alone
  p_pair_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_on && load[0] && en[1] && !busy[1]) |-> load[1]);

  // R11: no interrupt without a pending flag
  p_irq_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag != '0));
endmodule

bind dac_latch_ctrl dac_lc_checker #(.CAL_CYCLES(CAL_CYCLES)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .code0 (code0),
  .code1 (code1),
  .busy  (busy_w),
  .load  (load_w),
  .flag  (flag_o),
  .en    (en_w),
  .grp_on(grp_on_w),
  .irq   (irq)
);

// File: tb/sim_dac_latch_ctrl.sv
`timescale 1ns/1ps
module sim_dac_latch_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic        trig_a = 1'b0;
  logic        trig_b = 1'b0;
  logic [11:0] code0, code1;
  logic [1:0]  flag_o, cal_o;
  logic        irq;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  localparam logic [11:0] CAL = 12'h040;

  always #10 clk = ~clk;

  dac_latch_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trig_a(trig_a), .trig_b(trig_b),
    .code0(code0), .code1(code1), .flag_o(flag_o), .cal_o(cal_o), .irq(irq)
  );

  function automatic logic [11:0] mk(input int mode, input bit en, input bit grp,
                                     input bit fmt, input bit res8, input bit ie);
    logic [11:0] w;
    w = 12'(mode & 3);
    w[2] = en; w[3] = grp; w[4] = fmt; w[5] = res8; w[7] = ie;
    return w;
  endfunction

  function automatic logic [11:0] ref_code(input logic [11:0] d, input bit fmt, input bit res8);
    if (res8) return {4'h0, d[7] ^ fmt, d[6:0]};
    return {d[11] ^ fmt, d[10:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [11:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_a();
    @(negedge clk); trig_a = 1'b1;
    @(negedge clk); trig_a = 1'b0;
  endtask

  task automatic pulse_b();
    @(negedge clk); trig_b = 1'b1;
    @(negedge clk); trig_b = 1'b0;
  endtask

  task automatic wait_cal(input int ch);
    for (int k = 0; k < 300 && cal_o[ch]; k++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int n;
    logic [11:0] d;
    bit f, r;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 code0", code0, 0);
    chk("R1 code1", code1, 0);
    chk("R1 flags", flag_o, 0);
    chk("R1 cal", cal_o, 0);
    chk("R1 irq", irq, 0);

    // R2: immediate load, enable 0
    wr(0, mk(0, 0, 0, 0, 0, 0));
    wr(1, 12'hABC);
    chk("R2 imm load", code0, 12'hABC);
    chk("R11 flag set", flag_o[0], 1);
    chk("R11 irq needs ie", irq, 0);

    // R7: format
    wr(0, mk(0, 0, 0, 1, 0, 0));
    wr(1, 12'h123);
    chk("R7 twos 123", code0, ref_code(12'h123, 1, 0));
    wr(1, 12'hF00);
    chk("R7 twos F00", code0, 12'h700);

    // R8: narrow
    wr(0, mk(0, 0, 0, 0, 1, 0));
    wr(1, 12'hFA5);
    chk("R8 narrow bin", code0, 12'h0A5);
    wr(0, mk(0, 0, 0, 1, 1, 0));
    wr(1, 12'h025);
    chk("R8 narrow twos", code0, 12'h0A5);

    // R3: write load with enable
    wr(0, mk(1, 0, 0, 0, 0, 0));
    wr(1, 12'h111);
    chk("R3 disabled no load", code0, 12'h0A5);
    wr(0, mk(1, 1, 0, 0, 0, 0));
    wr(1, 12'h222);
    chk("R3 enabled load", code0, 12'h222);

    // R4: timer triggers
    wr(2, mk(2, 1, 0, 0, 0, 0));
    wr(3, 12'h345);
    chk("R4 write no load", code1, 0);
    @(negedge clk); trig_a = 1'b1;
    @(negedge clk);
    chk("R4 trig_a rise", code1, 12'h345);
    wr(3, 12'h346);
    chk("R4 level no load", code1, 12'h345);
    trig_a = 1'b0;
    @(negedge clk);
    pulse_b();
    chk("R4 other trigger", code1, 12'h345);
    wr(2, mk(3, 1, 0, 0, 0, 0));
    pulse_b();
    chk("R4 trig_b rise", code1, 12'h346);
    wr(2, mk(3, 0, 0, 0, 0, 0));
    wr(3, 12'h347);
    pulse_b();
    chk("R4 disabled trig", code1, 12'h346);

    // R11: flag clear and irq
    chk("R11 flag cleared by write", flag_o[1], 0);
    wr(2, mk(3, 1, 0, 0, 0, 1));
    pulse_b();
    chk("R11 load sets flag", flag_o[1], 1);
    chk("R11 irq", irq, 1);
    wr(2, mk(3, 1, 0, 0, 0, 1));
    chk("R11 irq cleared", irq, 0);

    // R5: grouped loading
    wr(0, mk(1, 1, 1, 0, 0, 0));
    wr(2, mk(1, 1, 0, 0, 0, 0));
    wr(1, 12'h0AA);
    chk("R5 hold code0", code0, 12'h222);
    chk("R5 hold code1", code1, 12'h347);
    wr(3, 12'h0BB);
    chk("R5 pair code0", code0, 12'h0AA);
    chk("R5 pair code1", code1, 12'h0BB);
    wr(3, 12'h0CC);
    chk("R5 rev hold", code1, 12'h0BB);
    wr(1, 12'h0DD);
    chk("R5 rev code0", code0, 12'h0DD);
    chk("R5 rev code1", code1, 12'h0CC);

    // R6: tracking cleared by configuration change
    wr(1, 12'h111);
    wr(2, mk(1, 1, 1, 0, 0, 0));
    wr(3, 12'h222);
    chk("R6 cleared code0", code0, 12'h0DD);
    chk("R6 cleared code1", code1, 12'h0CC);
    wr(1, 12'h333);
    chk("R6 reload code0", code0, 12'h333);
    chk("R6 reload code1", code1, 12'h222);

    // R9: calibration length
    wr(0, mk(0, 0, 0, 0, 0, 0) | CAL);
    n = 0;
    while (cal_o[0] && n < 300) begin
      n++;
      @(negedge clk);
    end
    chk("R9 cal length", n, 64);

    // R10: blocked loads during calibration
    wr(0, mk(0, 0, 0, 0, 0, 0) | CAL);
    wr(1, 12'h456);
    chk("R10 write dropped", code0, 12'h333);
    wait_cal(0);
    chk("R10 no late load", code0, 12'h333);
    wr(1, 12'h456);
    chk("R10 after cal", code0, 12'h456);
    wr(2, mk(2, 1, 0, 0, 0, 0));
    wr(3, 12'h789);
    wr(2, mk(2, 1, 0, 0, 0, 0) | CAL);
    pulse_a();
    chk("R10 trig dropped", code1, 12'h222);
    wait_cal(1);
    chk("R10 trig not late", code1, 12'h222);
    pulse_a();
    chk("R10 trig after cal", code1, 12'h789);

    // R7/R8 random
    for (int i = 0; i < 150; i++) begin
      f = 1'($urandom);
      r = 1'($urandom);
      d = 12'($urandom);
      wr(0, mk(0, 1'($urandom), 0, f, r, 0));
      wr(1, d);
      chk("R7 R8 random", code0, ref_code(d, f, r));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule